// File: doc/BRIEF.md
# MESI Snooping Cache-Line Coherence Controller

This block keeps the coherence state of every frame in a small direct-mapped, write-back private cache that sits on a shared snooping bus. Each frame holds a tag and one of four states: Invalid, Shared, Exclusive (clean and private) or Modified (dirty and private). On the processor side the block accepts one read or write request at a time and says in the same cycle whether it completes locally or must stall. When it must stall, it places one or more transactions on the bus: a line read, a read-for-ownership, an upgrade, or a write-back of a dirty victim.

On the bus side it watches the transactions of the other caches every cycle, including while its own request is pending. One cycle after a snooped transaction it drives a wired-OR shared indication and a flush strobe with the line address. It also moves its own copy to the state that the transaction requires. A processor request and a snoop can arrive in the same cycle. The snoop is treated as earlier in bus order, so the processor request sees the state the snoop leaves behind. The data array, bus arbitration and memory ordering are handled outside this block.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every frame is Invalid, `cpu_stall`, `bus_req`, `snp_shared` and `snp_flush` are low, and the first access to any address misses.
- R2: A read to a line held in Modified, Exclusive or Shared, and a write to a line held in Modified, raise `cpu_hit` in the same cycle with `bus_req` low.
- R3: A read miss places a line-read transaction (`bus_cmd` = 1) for the request address. `bus_shared_in` is sampled in the cycle after the grant. The line fills as Exclusive if that sample is low and as Shared if it is high.
- R4: A write to an Exclusive line hits in the same cycle, leaves the bus idle and makes the line Modified.
- R5: A write to a Shared line issues an upgrade (`bus_cmd` = 3). A write to an absent line issues a read-for-ownership (`bus_cmd` = 2). In both cases the line is Modified once the grant is taken.
- R6: A snooped line read to a line held in any valid state raises `snp_shared` in the next cycle. A snooped line read to a line not held leaves it low.
- R7: A snooped line read to a Modified line raises `snp_flush` with `snp_flush_addr` equal to the line address in the next cycle, and leaves the line Shared.
- R8: A snooped read-for-ownership to a Modified line flushes it and invalidates it. The same snoop to an Exclusive line invalidates it without a flush.
- R9: A snooped read-for-ownership or upgrade to a Shared line invalidates it without a flush.
- R10: A miss whose frame holds a different Modified line first issues a write-back (`bus_cmd` = 4) carrying the victim's address, then the fill transaction. A victim in Exclusive or Shared is dropped with no bus traffic.
- R11: While a transaction is pending, `cpu_hit` stays low, `cpu_stall` stays high, `bus_req` stays high until granted, and snoops are still answered.
- R12: When a snoop and a processor request reach the same line in one cycle, the snoop takes effect first. A write to an Exclusive line together with a snooped line read therefore misses and issues an upgrade.
- R13: A pending upgrade whose line is invalidated by a snoop before its grant goes out as a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until `cpu_hit` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request present but not completing |
| bus_req | output | 1 | Own transaction waiting for the bus |
| bus_cmd | output | 3 | 0 none, 1 line read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Line address of the own transaction |
| bus_gnt | input | 1 | Own transaction is on the bus this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Command of the snooped transaction, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| snp_shared | output | 1 | This cache holds the snooped line (one cycle later) |
| snp_flush | output | 1 | Dirty data supplied for the snooped line (one cycle later) |
| snp_flush_addr | output | ADDR_W | Address of the flushed line |

## Verification
The two functions that can meet in one cycle are the processor-side lookup and the snoop update of the same frame. They also meet when a snoop lands on the line a pending transaction is about to claim. The bench provokes the first case by raising a write to an Exclusive line and a snooped line read to it on the same edge. The write must not hit, the shared line must rise, and the expected upgrade must appear on the bus. It provokes the second case by holding back the grant on a pending upgrade, snooping a read-for-ownership to the line, and then releasing the grant. The scoreboard must then see a read-for-ownership in place of the upgrade.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_REQ    = 2'd1,
        PH_SAMPLE = 2'd2
    } phase_e;

    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] BC_NONE = 3'd0;
    localparam logic [CMD_W-1:0] BC_RD   = 3'd1;
    localparam logic [CMD_W-1:0] BC_RDX  = 3'd2;
    localparam logic [CMD_W-1:0] BC_UPGR = 3'd3;
    localparam logic [CMD_W-1:0] BC_WB   = 3'd4;

endpackage

// File: rtl/coh_snoop_xfer.sv
module coh_snoop_xfer
    import coh_pkg::*;
(
    input  logic              act,
    input  logic              match,
    input  logic [CMD_W-1:0]  cmd,
    input  mesi_e             cur_st,
    output mesi_e             nxt_st,
    output logic              shared,
    output logic              flush
);
    always_comb begin
        nxt_st = cur_st;
        shared = 1'b0;
        flush  = 1'b0;
        if (act && match) begin
            case (cmd)
                BC_RD: begin
                    shared = 1'b1;
                    flush  = (cur_st == ST_M);
                    if (cur_st == ST_M || cur_st == ST_E) nxt_st = ST_S;
                end
                BC_RDX: begin
                    flush  = (cur_st == ST_M);
                    nxt_st = ST_I;
                end
                BC_UPGR: begin
                    nxt_st = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/coh_cpu_xfer.sv
module coh_cpu_xfer
    import coh_pkg::*;
(
    input  logic  act,
    input  logic  tag_eq,
    input  logic  write,
    input  mesi_e cur_st,
    output logic  hit,
    output mesi_e nxt_st
);
    logic ok_rd;
    logic ok_wr;

    always_comb begin
        ok_rd  = (cur_st != ST_I);
        ok_wr  = (cur_st == ST_M) || (cur_st == ST_E);
        hit    = act && tag_eq && (write ? ok_wr : ok_rd);
        nxt_st = (hit && write) ? ST_M : cur_st;
    end
endmodule

// File: rtl/coh_cmd_sel.sv
module coh_cmd_sel
    import coh_pkg::*;
(
    input  logic             tag_eq,
    input  logic             write,
    input  mesi_e            cur_st,
    output logic [CMD_W-1:0] cmd,
    output logic             victim
);
    always_comb begin
        victim = (cur_st == ST_M) && !tag_eq;
        if (victim)
            cmd = BC_WB;
        else if (write)
            cmd = (tag_eq && cur_st == ST_S) ? BC_UPGR : BC_RDX;
        else
            cmd = BC_RD;
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [ADDR_W-1:0] snp_flush_addr
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [LINES-1:0][1:0]       st;
        logic [LINES-1:0][TAG_W-1:0] tag;
        phase_e                      phase;
        logic                        pend_wr;
        logic [ADDR_W-1:0]           pend_addr;
        logic                        shr;
        logic                        fl;
        logic [ADDR_W-1:0]           fl_addr;
    } ctl_t;

    ctl_t q, d;

    // snoop side lookup
    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    mesi_e            s_cur;
    mesi_e            s_nxt;
    logic             s_match;
    logic             s_shared;
    logic             s_flush;

    assign s_idx   = snp_addr[IDX_W-1:0];
    assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
    assign s_cur   = mesi_e'(q.st[s_idx]);
    assign s_match = (s_cur != ST_I) && (q.tag[s_idx] == s_tag);

    coh_snoop_xfer u_snoop (
        .act    (snp_valid),
        .match  (s_match),
        .cmd    (snp_cmd),
        .cur_st (s_cur),
        .nxt_st (s_nxt),
        .shared (s_shared),
        .flush  (s_flush)
    );

    // processor / own-transaction lookup, seen after the snoop
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  l_idx;
    logic [TAG_W-1:0]  l_tag;
    mesi_e             l_st;
    logic              l_teq;

    assign look_addr = (q.phase == PH_IDLE) ? cpu_addr : q.pend_addr;
    assign l_idx     = look_addr[IDX_W-1:0];
    assign l_tag     = look_addr[ADDR_W-1:IDX_W];
    assign l_st      = (snp_valid && s_idx == l_idx) ? s_nxt : mesi_e'(q.st[l_idx]);
    assign l_teq     = (l_st != ST_I) && (q.tag[l_idx] == l_tag);

    logic  c_act;
    logic  c_hit;
    mesi_e c_nxt;

    assign c_act = cpu_valid && (q.phase == PH_IDLE);

    coh_cpu_xfer u_cpu (
        .act    (c_act),
        .tag_eq (l_teq),
        .write  (cpu_write),
        .cur_st (l_st),
        .hit    (c_hit),
        .nxt_st (c_nxt)
    );

    logic [CMD_W-1:0] sel_cmd;
    logic             sel_victim;

    coh_cmd_sel u_sel (
        .tag_eq (l_teq),
        .write  (q.pend_wr),
        .cur_st (l_st),
        .cmd    (sel_cmd),
        .victim (sel_victim)
    );

    assign cpu_hit        = c_hit;
    assign cpu_stall      = cpu_valid && !c_hit;
    assign bus_req        = (q.phase == PH_REQ);
    assign bus_cmd        = bus_req ? sel_cmd : BC_NONE;
    assign bus_addr       = !bus_req ? '0 :
                            sel_victim ? {q.tag[l_idx], l_idx} : q.pend_addr;
    assign snp_shared     = q.shr;
    assign snp_flush      = q.fl;
    assign snp_flush_addr = q.fl_addr;

    always_comb begin
        d         = q;
        d.shr     = s_shared;
        d.fl      = s_flush;
        d.fl_addr = s_flush ? snp_addr : '0;
        if (snp_valid) d.st[s_idx] = s_nxt;

        case (q.phase)
            PH_IDLE: begin
                if (cpu_valid) begin
                    if (c_hit) begin
                        d.st[l_idx] = c_nxt;
                    end else begin
                        d.phase     = PH_REQ;
                        d.pend_wr   = cpu_write;
                        d.pend_addr = cpu_addr;
                    end
                end
            end
            PH_REQ: begin
                if (bus_gnt) begin
                    if (sel_victim) begin
                        d.st[l_idx] = ST_I;
                    end else if (sel_cmd == BC_RD) begin
                        d.phase = PH_SAMPLE;
                    end else begin
                        d.st[l_idx]  = ST_M;
                        d.tag[l_idx] = l_tag;
                        d.phase      = PH_IDLE;
                    end
                end
            end
            PH_SAMPLE: begin
                d.st[l_idx]  = bus_shared_in ? ST_S : ST_E;
                d.tag[l_idx] = l_tag;
                d.phase      = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    // R2: a local hit never coexists with an own bus request
    a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> !bus_req);

    // R4: a write hit on an Exclusive line leaves it Modified
    a_r4_e_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (c_act && cpu_write && c_hit && l_st == ST_E)
        |=> (q.st[$past(l_idx)] == ST_M) && !bus_req);

    // R7: snooped line read on a dirty line flushes and reports shared
    a_r7_m_rd_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_RD && s_match && s_cur == ST_M)
        |=> (snp_flush && snp_shared && snp_flush_addr == $past(snp_addr)));

    // R9: invalidating snoops on a Shared line leave it Invalid
    a_r9_s_inval: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == BC_RDX || snp_cmd == BC_UPGR) && s_match
         && s_cur == ST_S && q.phase == PH_IDLE)
        |=> (q.st[$past(s_idx)] == ST_I) && !snp_flush);

    // R11: a request is held until granted
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R3: a fill always ends clean (Exclusive or Shared)
    a_r3_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SAMPLE)
        |=> (q.st[$past(l_idx)] == ST_E || q.st[$past(l_idx)] == ST_S));

endmodule

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int IDX_W      = 3;

    localparam logic [2:0] C_RD = 3'd1, C_RDX = 3'd2, C_UPGR = 3'd3, C_WB = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_valid, cpu_write;
    logic [ADDR_W-1:0] cpu_addr;
    logic              cpu_hit, cpu_stall;
    logic              bus_req;
    logic [2:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_gnt;
    logic              bus_shared_in;
    logic              snp_valid;
    logic [2:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic              snp_shared, snp_flush;
    logic [ADDR_W-1:0] snp_flush_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_flush_addr(snp_flush_addr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit gnt_allow = 1'b1;
    logic [18:0] exp_q[$];
    string       exp_req[$];

    function automatic logic [ADDR_W-1:0] la(input int t, input int i);
        logic [ADDR_W-IDX_W-1:0] tt;
        logic [IDX_W-1:0]        ii;
        tt = t[ADDR_W-IDX_W-1:0];
        ii = i[IDX_W-1:0];
        return {tt, ii};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] c, input logic [ADDR_W-1:0] a, input string req);
        exp_q.push_back({c, a});
        exp_req.push_back(req);
    endtask

    // monitor: scoreboard for own bus transactions, also grants them
    initial begin
        bus_gnt = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && bus_req && gnt_allow) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10/R4", "unexpected bus txn", {13'd0, bus_cmd, bus_addr}, 32'd0);
                end else begin
                    logic [18:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = exp_req.pop_front();
                    chk({bus_cmd, bus_addr} == e, r, "bus txn", {13'd0, bus_cmd, bus_addr}, {13'd0, e});
                end
                bus_gnt = 1'b1;
            end else begin
                bus_gnt = 1'b0;
            end
        end
    end

    task automatic cpu_begin(input bit wr, input logic [ADDR_W-1:0] a, input bit shr);
        @(negedge clk);
        cpu_valid     = 1'b1;
        cpu_write     = wr;
        cpu_addr      = a;
        bus_shared_in = shr;
    endtask

    task automatic cpu_finish(input string req);
        int n = 0;
        while (!cpu_hit && n < 40) begin
            @(negedge clk);
            #3;
            n++;
        end
        chk(cpu_hit, req, "completion", {31'd0, cpu_hit}, 32'd1);
        chk(exp_q.size() == 0, req, "txns left", exp_q.size(), 32'd0);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a, input bit shr,
                          input bit exp_hit, input string req);
        cpu_begin(wr, a, shr);
        #3;
        chk(cpu_hit == exp_hit, req, "immediate hit", {31'd0, cpu_hit}, {31'd0, exp_hit});
        if (exp_hit)
            chk(!bus_req, req, "bus idle on hit", {31'd0, bus_req}, 32'd0);
        else
            chk(cpu_stall, req, "stall on miss", {31'd0, cpu_stall}, 32'd1);
        cpu_finish(req);
    endtask

    task automatic snoop(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                         input bit e_shr, input bit e_fl, input string req);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = c;
        snp_addr  = a;
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(snp_shared == e_shr, req, "snp_shared", {31'd0, snp_shared}, {31'd0, e_shr});
        chk(snp_flush == e_fl, req, "snp_flush", {31'd0, snp_flush}, {31'd0, e_fl});
        if (e_fl)
            chk(snp_flush_addr == a, req, "flush addr", {16'd0, snp_flush_addr}, {16'd0, a});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        chk(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_valid = 0; cpu_write = 0; cpu_addr = '0;
        bus_shared_in = 0; snp_valid = 0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!cpu_stall && !bus_req && !snp_shared && !snp_flush, "R1", "idle outputs",
            {28'd0, cpu_stall, bus_req, snp_shared, snp_flush}, 32'd0);

        // R1 R3: first read misses, fills Exclusive (shared low)
        push(C_RD, la(1,0), "R3");
        cpu_op(1'b0, la(1,0), 1'b0, 1'b0, "R1");
        cpu_op(1'b1, la(1,0), 1'b0, 1'b1, "R4");   // E -> M silently
        cpu_op(1'b0, la(1,0), 1'b0, 1'b1, "R2");
        cpu_op(1'b1, la(1,0), 1'b0, 1'b1, "R2");

        // R6 R7: snooped read on M: flush, shared, line to S
        snoop(C_RD, la(1,0), 1'b1, 1'b1, "R7");
        push(C_UPGR, la(1,0), "R5");
        cpu_op(1'b1, la(1,0), 1'b0, 1'b0, "R5");

        // R8: read-for-ownership on M flushes and invalidates
        snoop(C_RDX, la(1,0), 1'b0, 1'b1, "R8");
        push(C_RD, la(1,0), "R8");
        cpu_op(1'b0, la(1,0), 1'b1, 1'b0, "R8");    // fills Shared
        cpu_op(1'b0, la(1,0), 1'b0, 1'b1, "R2");    // read hit on S
        snoop(C_RD, la(1,0), 1'b1, 1'b0, "R6");
        snoop(C_UPGR, la(1,0), 1'b0, 1'b0, "R9");
        push(C_RD, la(1,0), "R9");
        cpu_op(1'b0, la(1,0), 1'b0, 1'b0, "R9");    // was invalid, now E
        snoop(C_RDX, la(1,0), 1'b0, 1'b0, "R8");    // E invalidated, no flush
        push(C_RD, la(1,0), "R8");
        cpu_op(1'b0, la(1,0), 1'b0, 1'b0, "R8");
        snoop(C_RD, la(9,1), 1'b0, 1'b0, "R6");     // not held

        // R10: clean victim silent, dirty victim written back
        push(C_RD, la(2,0), "R10");
        cpu_op(1'b0, la(2,0), 1'b0, 1'b0, "R10");
        cpu_op(1'b1, la(2,0), 1'b0, 1'b1, "R4");
        push(C_WB, la(2,0), "R10");
        push(C_RD, la(3,0), "R10");
        cpu_op(1'b0, la(3,0), 1'b0, 1'b0, "R10");
        push(C_RDX, la(4,1), "R5");
        cpu_op(1'b1, la(4,1), 1'b0, 1'b0, "R5");
        cpu_op(1'b0, la(4,1), 1'b0, 1'b1, "R2");

        // R11: snoops serviced while own request pending
        push(C_RDX, la(5,2), "R5");
        cpu_op(1'b1, la(5,2), 1'b0, 1'b0, "R5");
        gnt_allow = 1'b0;
        push(C_RD, la(6,3), "R11");
        cpu_begin(1'b0, la(6,3), 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #3;
            chk(cpu_stall && !cpu_hit && bus_req, "R11", "pending",
                {29'd0, cpu_stall, cpu_hit, bus_req}, 32'd5);
        end
        snoop(C_RD, la(5,2), 1'b1, 1'b1, "R11");
        gnt_allow = 1'b1;
        cpu_finish("R11");

        // R12: same-cycle write on E and snooped read to that line
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = la(6,3);
        snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = la(6,3);
        #3;
        chk(!cpu_hit, "R12", "write blocked by snoop", {31'd0, cpu_hit}, 32'd0);
        push(C_UPGR, la(6,3), "R12");
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(snp_shared && !snp_flush, "R12", "snoop reply", {30'd0, snp_shared, snp_flush}, 32'd2);
        cpu_finish("R12");

        // R13: pending upgrade turned into read-for-ownership
        push(C_RD, la(7,4), "R3");
        cpu_op(1'b0, la(7,4), 1'b1, 1'b0, "R3");    // fills Shared
        gnt_allow = 1'b0;
        push(C_RDX, la(7,4), "R13");
        cpu_begin(1'b1, la(7,4), 1'b0);
        @(negedge clk);
        #3;
        chk(bus_req && bus_cmd == C_UPGR, "R5", "upgrade pending", {28'd0, bus_req, bus_cmd}, {28'd0, 1'b1, C_UPGR});
        snoop(C_RDX, la(7,4), 1'b0, 1'b0, "R9");
        gnt_allow = 1'b1;
        cpu_finish("R13");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule